// File: doc/BRIEF.md
# ROM Signature Checksum Engine

This block computes a 16-bit signature over a character ROM when a host asks for one. The host writes a one into the start bit of a control register on a byte-wide register bus. The engine then drives the ROM's synchronous read port through every location, from the lowest address to the highest, one location per cycle. It adds each returned word into a running sum using end-around carry, so the sum is reduced modulo 65535. When the last word has been added, the engine stores the folded sum in a 16-bit result register and drops the start bit by itself.

The start bit also serves as the busy flag. The host polls it and, once it reads zero, fetches the two result bytes. The result register keeps the previous signature for the whole of a pass. A ROM with a given content always gives the same signature, so the engine can be used to verify the contents of a masked ROM.

Top module: `romSigEngine`

## Requirements
- R1: After reset, the control register and both result bytes read 0x00, and the ROM read enable is low.
- R2: The register map and its decode are as follows. Bit 0 of the control byte at 0x840D is start/busy, and its bits 7..1 always read 0. The result low byte is at 0x840E and the high byte at 0x840F. Any other address reads 0x00. Reads are combinational from the address.
- R3: Writing a control byte with bit 0 = 1 while idle starts a pass. From the next cycle, the ROM read enable stays high for ROM_DEPTH consecutive cycles, and the address steps from 0 up to ROM_DEPTH-1 by one on each cycle.
- R4: The result equals the sum of all ROM words, taken as unsigned numbers, modulo 65535. Carries out of bit 15 are added back into bit 0, and a final 0xFFFF is stored as 0x0000.
- R5: The busy bit reads 1 for exactly ROM_DEPTH+1 cycles counted from the write edge. The new result can be read in the first cycle in which busy reads 0.
- R6: Control writes made during a pass have no effect, whether bit 0 is 0 or 1. Busy stays set, and the pass keeps its length and its result.
- R7: The result register holds the previous signature until the running pass completes.
- R8: A control write with bit 0 = 0 while idle starts nothing, whatever the values of bits 7..1.
- R9: The accumulator is cleared at the start of every pass. Repeating a pass over the same contents gives the same signature, whatever the previous pass computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe for one cycle |
| busAddr | input | BUS_AW | Register byte address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data, combinational from busAddr |
| romRe | output | 1 | ROM read enable |
| romAddr | output | $clog2(ROM_DEPTH) | ROM read address |
| romData | input | DATA_W | ROM read data, valid one cycle after romRe |

## Verification
The bench builds the engine with DATA_W = 16 and the default ROM_DEPTH = 256. With 8-bit words, the largest possible sum stays below 65535, so the end-around carry and the 0xFFFF fold could never occur. Sixteen-bit words make both reachable: one pattern sums to 65535+6, and an all-ones ROM accumulates to 0xFFFF, which is then stored as zero. The full 256-entry depth exercises the address counter wrap at its last step and the exact pass length of 257 busy cycles.

// File: rtl/romsig_pkg.sv
package romsig_pkg;

  typedef enum logic [1:0] {
    SIG_IDLE  = 2'd0,
    SIG_RUN   = 2'd1,
    SIG_DRAIN = 2'd2
  } sigState_t;

  // Strobes from the sequencer to the accumulator
  typedef struct packed {
    logic clearAcc;  // start of a pass: zero the running sum
    logic addWord;   // romData carries a word of this pass
    logic commit;    // last word: store the folded sum
  } sigStrobe_t;

endpackage

// File: rtl/romsig_ctrl.sv
module romsig_ctrl
  import romsig_pkg::*;
#(
  parameter int ROM_DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         startReq,
  output logic                         busy,
  output logic                         romRe,
  output logic [$clog2(ROM_DEPTH)-1:0] romAddr,
  output sigStrobe_t                   strb
);

  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam logic [ROM_AW-1:0] LAST_ADDR = ROM_AW'(ROM_DEPTH - 1);

  sigState_t         state;
  logic [ROM_AW-1:0] addrCnt;
  logic              dataValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SIG_IDLE;
      addrCnt   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= (state == SIG_RUN);
      unique case (state)
        SIG_IDLE: begin
          if (startReq) begin
            state   <= SIG_RUN;
            addrCnt <= '0;
          end
        end
        SIG_RUN: begin
          addrCnt <= addrCnt + 1'b1;
          if (addrCnt == LAST_ADDR) state <= SIG_DRAIN;
        end
        SIG_DRAIN: state <= SIG_IDLE;
        default:   state <= SIG_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (state != SIG_IDLE);
    romRe         = (state == SIG_RUN);
    romAddr       = addrCnt;
    strb.clearAcc = (state == SIG_IDLE) && startReq;
    strb.addWord  = dataValid;
    strb.commit   = (state == SIG_DRAIN);
  end

  // R3: consecutive reads walk the ROM one address at a time
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (romRe && $past(romRe)) |-> (romAddr == $past(romAddr) + 1'b1));

  // R3: a pass always begins at address zero
  p_addr_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(romRe) |-> (romAddr == '0));

  // R5: the drain cycle is the last busy cycle
  p_drain_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SIG_DRAIN) |=> !busy);

  // R6: a start request during a pass does not restart the walk
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SIG_RUN && startReq && addrCnt != LAST_ADDR)
      |=> (addrCnt == $past(addrCnt) + 1'b1 && state == SIG_RUN));

endmodule

// File: rtl/romsig_datapath.sv
module romsig_datapath
  import romsig_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sigStrobe_t        strb,
  input  logic [DATA_W-1:0] romData,
  output logic [SUM_W-1:0]  result
);

  logic [SUM_W-1:0] acc;
  logic [SUM_W:0]   rawSum;
  logic [SUM_W-1:0] wrapSum;
  logic [SUM_W-1:0] foldSum;

  // One's-complement addition: carry out wraps into bit 0
  always_comb begin
    rawSum  = {1'b0, acc} + (SUM_W + 1)'(romData);
    wrapSum = rawSum[SUM_W-1:0] + SUM_W'(rawSum[SUM_W]);
    foldSum = (wrapSum == '1) ? '0 : wrapSum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (strb.clearAcc)     acc <= '0;
      else if (strb.addWord) acc <= wrapSum;
      if (strb.commit)       result <= foldSum;
    end
  end

  // R4: the stored signature never holds the all-ones value
  p_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result != '1);

  // R7: the signature only changes on commit
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(result));

  // R9: every pass starts from a zero sum
  p_acc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAcc |=> (acc == '0));

endmodule

// File: rtl/romSigEngine.sv
module romSigEngine
  import romsig_pkg::*;
#(
  parameter int              ROM_DEPTH   = 256,
  parameter int              DATA_W      = 8,
  parameter int              BUS_AW      = 16,
  parameter logic [BUS_AW-1:0] CTRL_ADDR   = 16'h840D,
  parameter logic [BUS_AW-1:0] RES_LO_ADDR = 16'h840E,
  parameter logic [BUS_AW-1:0] RES_HI_ADDR = 16'h840F
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         busWe,
  input  logic [BUS_AW-1:0]            busAddr,
  input  logic [7:0]                   busWdata,
  output logic [7:0]                   busRdata,
  output logic                         romRe,
  output logic [$clog2(ROM_DEPTH)-1:0] romAddr,
  input  logic [DATA_W-1:0]            romData
);

  localparam int SUM_W = 16;

  sigStrobe_t       strb;
  logic             busy;
  logic             startReq;
  logic [SUM_W-1:0] result;
  logic             unusedWdata;

  assign startReq    = busWe && (busAddr == CTRL_ADDR) && busWdata[0];
  assign unusedWdata = ^busWdata[7:1];

  romsig_ctrl #(.ROM_DEPTH(ROM_DEPTH)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .busy     (busy),
    .romRe    (romRe),
    .romAddr  (romAddr),
    .strb     (strb)
  );

  romsig_datapath #(.DATA_W(DATA_W), .SUM_W(SUM_W)) uPath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .romData (romData),
    .result  (result)
  );

  always_comb begin
    if (busAddr == CTRL_ADDR)        busRdata = {7'b0, busy};
    else if (busAddr == RES_LO_ADDR) busRdata = result[7:0];
    else if (busAddr == RES_HI_ADDR) busRdata = result[15:8];
    else                             busRdata = 8'h00;
  end

  // R2: reserved control bits read as zero
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == CTRL_ADDR) |-> (busRdata[7:1] == 7'b0));

  // R8: a write without bit 0 leaves an idle engine idle
  p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busWe && busAddr == CTRL_ADDR && !busWdata[0]) |=> !busy);

endmodule

// File: tb/tb_romSigEngine.sv
`timescale 1ns/1ps
module tb_romSigEngine;

  localparam int DEPTH  = 256;
  localparam int DW     = 16;
  localparam logic [15:0] A_CTRL = 16'h840D;
  localparam logic [15:0] A_LO   = 16'h840E;
  localparam logic [15:0] A_HI   = 16'h840F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busWe = 1'b0;
  logic [15:0]   busAddr = 16'h0000;
  logic [7:0]    busWdata = 8'h00;
  logic [7:0]    busRdata;
  logic          romRe;
  logic [7:0]    romAddr;
  logic [DW-1:0] romData;

  romSigEngine #(.ROM_DEPTH(DEPTH), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .romRe(romRe),
    .romAddr(romAddr), .romData(romData)
  );

  always #5 clk = ~clk;

  // Synchronous-read ROM model
  logic [DW-1:0] rom [DEPTH];
  logic [DW-1:0] romQ = '0;
  always @(posedge clk) if (romRe) romQ <= rom[romAddr];
  assign romData = romQ;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Address walk monitor (R3)
  int   addrSeen = 0;
  bit   addrBad = 1'b0;
  logic [7:0] expAddr = 8'h00;
  always @(negedge clk) if (romRe) begin
    if (romAddr != expAddr) addrBad = 1'b1;
    expAddr  = expAddr + 8'h01;
    addrSeen = addrSeen + 1;
  end

  logic [15:0] expQ [$];
  logic [15:0] lastSig = 16'h0000;
  event passDone;
  bit   monDone = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = 8'h00;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic fillRom(input int kind);
    for (int i = 0; i < DEPTH; i++) begin
      case (kind)
        0: rom[i] = '0;
        1: rom[i] = DW'(i);
        2: rom[i] = DW'(8'hFF);
        3: rom[i] = '1;
        4: rom[i] = DW'((i * 40503 + 12345) & 16'hFFFF);
        5: rom[i] = (i == 0) ? 16'hFFFF : ((i == 1) ? 16'h0006 : 16'h0000);
        default: rom[i] = '0;
      endcase
    end
  endtask

  // Driver: computes the expected signature, pushes it, runs a pass
  task automatic runPass(input int kind, input bit poke);
    longint sum = 0;
    logic [7:0] v;
    int startCyc;
    fillRom(kind);
    for (int i = 0; i < DEPTH; i++) sum += longint'(rom[i]);
    expQ.push_back(16'(sum % 65535));
    addrSeen = 0; addrBad = 1'b0; expAddr = 8'h00;
    busWrite(A_CTRL, 8'h01);
    startCyc = cyc;
    if (poke) begin
      repeat (10) @(negedge clk);
      busWrite(A_CTRL, 8'h00);
      busRead(A_CTRL, v);
      check(v == 8'h01, "R6 busy after write 0", v, 8'h01);
      busRead(A_LO, v);
      check(v == lastSig[7:0], "R7 old result low", v, lastSig[7:0]);
      busRead(A_HI, v);
      check(v == lastSig[15:8], "R7 old result high", v, lastSig[15:8]);
      repeat (80) @(negedge clk);
      busWrite(A_CTRL, 8'hFF);
      busRead(A_CTRL, v);
      check(v == 8'h01, "R6 busy after write 1", v, 8'h01);
    end
    forever begin
      busRead(A_CTRL, v);
      if (!v[0]) break;
      @(negedge clk);
    end
    check((cyc - startCyc) == DEPTH + 1, "R5 busy length", cyc - startCyc, DEPTH + 1);
    check(!addrBad && addrSeen == DEPTH, "R3 address walk", addrSeen, DEPTH);
    ->passDone;
    wait (monDone);
    monDone = 1'b0;
  endtask

  // Monitor: pops the expected signature and compares the register value
  initial begin
    logic [7:0] lo, hi;
    logic [15:0] e;
    forever begin
      @(passDone);
      e = expQ.pop_front();
      busRead(A_LO, lo);
      busRead(A_HI, hi);
      check({hi, lo} == e, "R4 signature", {hi, lo}, e);
      lastSig = {hi, lo};
      monDone = 1'b1;
    end
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] firstSig;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(A_CTRL, v); check(v == 8'h00, "R1 ctrl after reset", v, 0);
    busRead(A_LO, v);   check(v == 8'h00, "R1 result low after reset", v, 0);
    busRead(A_HI, v);   check(v == 8'h00, "R1 result high after reset", v, 0);
    check(romRe == 1'b0, "R1 romRe after reset", romRe, 0);
    // R2 unmapped address
    busRead(16'h8410, v); check(v == 8'h00, "R2 unmapped read", v, 0);
    // R8 reserved bits without start
    busWrite(A_CTRL, 8'hFE);
    busRead(A_CTRL, v); check(v == 8'h00, "R8 no start, R2 reserved zero", v, 0);
    repeat (3) @(negedge clk);
    check(romRe == 1'b0, "R8 romRe stays low", romRe, 0);

    runPass(1, 1'b0);   // incrementing words
    runPass(2, 1'b0);   // all 0xFF
    runPass(5, 1'b1);   // end-around carry, with pokes during the pass (R6, R7)
    runPass(3, 1'b0);   // all ones: folds to zero (R4)
    runPass(0, 1'b0);   // all zeros
    runPass(4, 1'b0);   // mixed words
    firstSig = lastSig;
    runPass(2, 1'b0);
    runPass(4, 1'b0);
    check(lastSig == firstSig, "R9 repeat gives same signature", lastSig, firstSig);

    busRead(A_CTRL, v); check(v == 8'h00, "R2 ctrl idle reads zero", v, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule